// File: doc/BRIEF.md
# Field Event Interrupt Controller

This block gathers field-start pulses from a video timing generator and turns them into a level interrupt for a host processor. Each pulse sets a sticky bit in a pending register; an enable register chooses which pending bits may drive the interrupt line.

Software never has to read, modify and write either register. The pending register is cleared by writing ones to a clear address. The enable register is changed only by writing ones to a set address or a clear address. The pending and enable registers can both be read back at their own addresses. A host handler reads the pending bits and writes the same value to the clear address. It then reads the pending bits again to confirm that the clear has taken effect.

Top module: `field_irq_ctrl`

## Requirements
- R1: After reset, the pending and enable registers read as zero and `irq` is low.
- R2: A one-cycle pulse on `evt_bot` sets pending bit 0, and a pulse on `evt_top` sets pending bit 1. Once set, a bit stays set until it is cleared.
- R3: A read of address 0 (pending) or address 3 (enable) returns the register value, zero-extended to DATA_W bits, on `rd_data` in the cycle after `rd_en`. Any other read address returns zero.
- R4: A write to address 1 (pending clear) clears every pending bit written as 1 and leaves the bits written as 0 unchanged. The new value is visible from the next cycle.
- R5: A write to address 2 (enable set) sets every enable bit written as 1. A write to address 3 (enable clear) clears every enable bit written as 1. Bits written as 0 are unchanged.
- R6: `irq` is high exactly when the bitwise AND of the pending and enable registers is nonzero, with no added register stage.
- R7: If an event arrives in the same cycle as a clear write to its pending bit, the bit stays set.
- R8: A write of all ones to the pending clear address and to the enable clear address leaves no pending bit, no enable bit and a low `irq`.
- R9: A write to address 0 has no effect on the pending register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register address |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| evt_bot | input | 1 | Bottom-field start pulse |
| evt_top | input | 1 | Top-field start pulse |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle, the assertions check the interrupt equation, that events stay sticky, that an event wins over a clear, and that writes with 0 bits leave those bits unchanged in both registers. Only the bench scenarios can show the real address decoding and the read-back timing. The bench also runs the host handler sequence (read, write back to clear, read again), checks that the all-ones clears leave the block quiet, and checks that a write to address 0 is ignored.

// File: rtl/field_irq_ctrl.sv
module field_irq_ctrl #(
  parameter int DATA_W = 16,
  parameter int EVT_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              evt_bot,
  input  logic              evt_top,
  output logic              irq
);
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_SCLR = 2'd1;
  localparam logic [1:0] A_MSET = 2'd2;
  localparam logic [1:0] A_MCLR = 2'd3;

  logic [EVT_N-1:0] stat_q, mask_q, evt, sclr, mset, mclr;

  assign evt  = {evt_top, evt_bot};
  assign sclr = (wr_en && addr == A_SCLR) ? wr_data[EVT_N-1:0] : '0;
  assign mset = (wr_en && addr == A_MSET) ? wr_data[EVT_N-1:0] : '0;
  assign mclr = (wr_en && addr == A_MCLR) ? wr_data[EVT_N-1:0] : '0;
  assign irq  = |(stat_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      rd_data <= '0;
    end else begin
      stat_q <= (stat_q & ~sclr) | evt;
      mask_q <= (mask_q & ~mclr) | mset;
      if (rd_en) begin
        case (addr)
          A_STAT:  rd_data <= DATA_W'(stat_q);
          A_MCLR:  rd_data <= DATA_W'(mask_q);
          default: rd_data <= '0;
        endcase
      end
    end
  end

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((stat_q & mask_q) != '0));
  assert_evt_top_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_top |=> stat_q[1]);
  assert_evt_bot_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bot |=> stat_q[0]);
  assert_evt_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SCLR && wr_data[1] && evt_top) |=> stat_q[1]);
  assert_clear_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SCLR && !wr_data[0] && stat_q[0]) |=> stat_q[0]);
  assert_mask_zero_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MCLR && !wr_data[1] && mask_q[1]) |=> mask_q[1]);
endmodule

// File: tb/field_irq_ctrl_tb.sv
module field_irq_ctrl_tb;
  localparam int DW = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, evt_bot = 0, evt_top = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wr_data = 0, rd_data;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  field_irq_ctrl #(.DATA_W(DW)) u_dut (.*);

  always #4 clk = ~clk;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic pulse(logic t, logic b);
    @(negedge clk); evt_top = t; evt_bot = b;
    @(negedge clk); evt_top = 0; evt_bot = 0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    check("R1 irq", DW'(irq), 0);
    rd(0, d); check("R1 pending", d, 0);
    rd(3, d); check("R1 enable", d, 0);
  endtask

  task automatic t_events;
    logic [DW-1:0] d;
    pulse(0, 1); rd(0, d); check("R2 bottom bit0", d, 16'h1);
    pulse(1, 0); rd(0, d); check("R2 top bit1 sticky", d, 16'h3);
    rd(2, d); check("R3 unused addr reads zero", d, 0);
    check("R6 irq masked", DW'(irq), 0);
  endtask

  task automatic t_mask;
    logic [DW-1:0] d;
    wr(2, 16'h2); rd(3, d); check("R5 set", d, 16'h2);
    check("R6 irq top enabled", DW'(irq), 1);
    wr(2, 16'h1); rd(3, d); check("R5 set keeps", d, 16'h3);
    wr(3, 16'h2); rd(3, d); check("R5 clear bit1 only", d, 16'h1);
  endtask

  task automatic t_handler;
    logic [DW-1:0] s, d;
    wr(0, 16'hFFFF); rd(0, d); check("R9 write addr0 ignored", d, 16'h3);
    rd(0, s); wr(1, 16'h1); rd(0, d); check("R4 partial clear", d, 16'h2);
    check("R6 irq low after clear", DW'(irq), 0);
    rd(0, s); wr(1, s); rd(0, d); check("R4 handler clear", d, 0);
  endtask

  task automatic t_race;
    logic [DW-1:0] d;
    @(negedge clk); wr_en = 1; addr = 1; wr_data = 16'h2; evt_top = 1;
    @(negedge clk); wr_en = 0; evt_top = 0;
    rd(0, d); check("R7 event beats clear", d, 16'h2);
  endtask

  task automatic t_allclear;
    logic [DW-1:0] d;
    wr(2, 16'hFFFF); pulse(1, 1);
    check("R6 irq both", DW'(irq), 1);
    wr(1, 16'hFFFF); wr(3, 16'hFFFF);
    rd(0, d); check("R8 pending zero", d, 0);
    rd(3, d); check("R8 enable zero", d, 0);
    check("R8 irq low", DW'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_events(); t_mask(); t_handler(); t_race(); t_allclear();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule